// File: doc/BRIEF.md
# Embedded Trigger-and-Capture Logic Analyzer

This block is an on-chip logic analyzer that sits next to the logic under observation. On one sampling clock it watches a wide bus of probe signals and a narrower group of trigger inputs. A host arms it. From that point it compares the trigger inputs against a programmable match value, and only the bit positions selected by a programmable mask take part in the comparison. An optional external trigger line can also start the capture. In the cycle the condition becomes true, the probe bus is written to slot 0 of an internal sample memory. The following consecutive cycles fill the remaining slots until the memory holds a fixed number of samples.

A host works the analyzer through a small register-style port. It writes the match value, the mask and a control word that arms the analyzer and enables the external trigger. It then polls a three-flag status vector. When capture is complete it reads the stored words back by index. A counter reports how many armed cycles passed before the trigger fired, which locates the record in time relative to arming. Trigger events are ignored unless the analyzer is armed, so a finished record cannot be overwritten until the host arms the analyzer again.

Top module: `la_capture_top`

## Requirements
- R1: While reset is high and right after it, `status_o` is 3'b000, `rd_data_o` is zero, `trig_delay_o` is zero, the mask register holds all ones and the match register holds zero.
- R2: While armed, an internal trigger fires when every trigger input bit whose mask bit is 1 equals the corresponding match bit. Bits whose mask bit is 0 are don't-care, so an all-zero mask fires on the first armed cycle.
- R3: When control bit 1 (external enable) is set, a high `ext_trig_i` in an armed cycle also fires the trigger. When that bit is clear, `ext_trig_i` has no effect.
- R4: Trigger conditions seen while not armed change nothing. This holds when idle and when the capture is done: status, delay count and stored samples stay as they were.
- R5: The probe value present in the firing cycle is stored at index 0. The next DEPTH-1 cycles are stored at indices 1 to DEPTH-1. Status reads done after the edge that stores index DEPTH-1, and not before.
- R6: `status_o` bit 0 is armed, bit 1 is triggered and bit 2 is done. The only legal values are 3'b000 (idle), 3'b001 (armed), 3'b010 (capturing) and 3'b110 (done).
- R7: A read index presented at one rising edge returns that slot's stored word on `rd_data_o` after that edge. The output is zero unless the analyzer was done at that edge.
- R8: `trig_delay_o` counts the armed cycles that passed without a trigger. It saturates at its all-ones value and holds once the trigger has fired.
- R9: Arming restarts the analyzer from any state. After the arming edge the status is 3'b001, the delay count is zero and readout is blocked again.
- R10: A write with `cfg_sel_i` = 0 loads the match value and a write with `cfg_sel_i` = 1 loads the mask. A write with `cfg_sel_i` = 2 is the control word: bit 0 = 1 arms the analyzer and bit 1 sets the external enable. Writes take effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for probing, triggering and storage |
| rst | input | 1 | Synchronous active-high reset |
| probe_i | input | PROBE_W | Signals recorded into the sample memory |
| trig_i | input | TRIG_W | Internal trigger inputs (up to 64) |
| ext_trig_i | input | 1 | External trigger input |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 match, 1 mask, 2 control |
| cfg_data_i | input | TRIG_W | Write data (control uses bits 0 and 1) |
| rd_idx_i | input | $clog2(DEPTH) | Sample index to read |
| rd_data_o | output | PROBE_W | Stored sample, one cycle after the index |
| status_o | output | 3 | {done, triggered, armed} |
| trig_delay_o | output | CNT_W | Armed cycles before the trigger, saturating |

## Verification
The bench builds the analyzer with a 4-bit trigger group, an 8-bit probe bus, a 16-slot memory and a 6-bit delay counter. With these values every one of the 256 combinations of mask and trigger input can be tried against a fixed match value, and each full record can be read back and compared slot by slot against an arithmetic probe pattern. The delay counter reaches its saturation point after a wait of about seventy cycles. Two records with different probe patterns are captured, one after a delay and one that fires on the first armed cycle. Re-arming is also tested in the middle of a capture.

// File: rtl/la_pkg.sv
package la_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAPT  = 2'd2,
        ST_DONE  = 2'd3
    } la_state_e;

    typedef struct packed {
        logic done;
        logic triggered;
        logic armed;
    } la_status_t;

    localparam logic [1:0] SEL_MATCH = 2'd0;
    localparam logic [1:0] SEL_MASK  = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    localparam int CTRL_ARM_BIT = 0;
    localparam int CTRL_EXT_BIT = 1;

    function automatic la_status_t status_of(la_state_e s);
        la_status_t r;
        r.armed     = (s == ST_ARMED);
        r.triggered = (s == ST_CAPT) || (s == ST_DONE);
        r.done      = (s == ST_DONE);
        return r;
    endfunction

endpackage

// File: rtl/la_trigger_match.sv
module la_trigger_match #(
    parameter int TRIG_W = 16
) (
    input  logic [TRIG_W-1:0] trig_i,
    input  logic [TRIG_W-1:0] match_i,
    input  logic [TRIG_W-1:0] mask_i,
    input  logic              ext_trig_i,
    input  logic              ext_en_i,
    output logic              hit_o
);

    logic [TRIG_W-1:0] bit_ok;

    for (genvar i = 0; i < TRIG_W; i++) begin : g_bit
        assign bit_ok[i] = ~mask_i[i] | (trig_i[i] ~^ match_i[i]);
    end

    assign hit_o = (&bit_ok) | (ext_en_i & ext_trig_i);

endmodule

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [WIDTH-1:0] rd_data_o
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end
        rd_data_o <= mem[rd_addr_i];
    end

endmodule

// File: rtl/la_capture_fsm.sv
module la_capture_fsm
    import la_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CNT_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             hit_i,
    output la_state_e        state_o,
    output logic             wr_en_o,
    output logic [AW-1:0]    wr_addr_o,
    output logic [CNT_W-1:0] delay_o
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    la_state_e        state_q;
    logic [AW-1:0]    wptr_q;
    logic [CNT_W-1:0] delay_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wptr_q  <= '0;
            delay_q <= '0;
        end else if (arm_i) begin
            state_q <= ST_ARMED;
            wptr_q  <= '0;
            delay_q <= '0;
        end else begin
            unique case (state_q)
                ST_ARMED: begin
                    if (hit_i) begin
                        state_q <= ST_CAPT;
                        wptr_q  <= AW'(1);
                    end else if (!(&delay_q)) begin
                        delay_q <= delay_q + 1'b1;
                    end
                end
                ST_CAPT: begin
                    if (wptr_q == LAST) begin
                        state_q <= ST_DONE;
                    end else begin
                        wptr_q <= wptr_q + 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        wr_en_o   = ((state_q == ST_ARMED) && hit_i) || (state_q == ST_CAPT);
        wr_addr_o = wptr_q;
        state_o   = state_q;
        delay_o   = delay_q;
    end

endmodule

// File: rtl/la_capture_top.sv
module la_capture_top
    import la_pkg::*;
#(
    parameter int PROBE_W = 32,
    parameter int TRIG_W  = 16,
    parameter int DEPTH   = 128,
    parameter int CNT_W   = 16,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PROBE_W-1:0] probe_i,
    input  logic [TRIG_W-1:0]  trig_i,
    input  logic               ext_trig_i,
    input  logic               cfg_wr_i,
    input  logic [1:0]         cfg_sel_i,
    input  logic [TRIG_W-1:0]  cfg_data_i,
    input  logic [AW-1:0]      rd_idx_i,
    output logic [PROBE_W-1:0] rd_data_o,
    output logic [2:0]         status_o,
    output logic [CNT_W-1:0]   trig_delay_o
);

    logic [TRIG_W-1:0]  match_q;
    logic [TRIG_W-1:0]  mask_q;
    logic               ext_en_q;
    logic               rd_gate_q;
    logic               arm_req;
    logic               hit;
    la_state_e          state;
    la_status_t         stat;
    logic               wr_en;
    logic [AW-1:0]      wr_addr;
    logic [PROBE_W-1:0] ram_q;

    assign arm_req = cfg_wr_i && (cfg_sel_i == SEL_CTRL) && cfg_data_i[CTRL_ARM_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q  <= '0;
            mask_q   <= '1;
            ext_en_q <= 1'b0;
        end else if (cfg_wr_i) begin
            unique case (cfg_sel_i)
                SEL_MATCH: match_q  <= cfg_data_i;
                SEL_MASK:  mask_q   <= cfg_data_i;
                SEL_CTRL:  ext_en_q <= cfg_data_i[CTRL_EXT_BIT];
                default: begin
                end
            endcase
        end
    end

    la_trigger_match #(
        .TRIG_W (TRIG_W)
    ) u_match (
        .trig_i     (trig_i),
        .match_i    (match_q),
        .mask_i     (mask_q),
        .ext_trig_i (ext_trig_i),
        .ext_en_i   (ext_en_q),
        .hit_o      (hit)
    );

    la_capture_fsm #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .arm_i     (arm_req),
        .hit_i     (hit),
        .state_o   (state),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .delay_o   (trig_delay_o)
    );

    la_sample_ram #(
        .WIDTH (PROBE_W),
        .DEPTH (DEPTH)
    ) u_ram (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (probe_i),
        .rd_addr_i (rd_idx_i),
        .rd_data_o (ram_q)
    );

    assign stat = status_of(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_gate_q <= 1'b0;
        end else begin
            rd_gate_q <= stat.done;
        end
    end

    assign rd_data_o = rd_gate_q ? ram_q : '0;
    assign status_o  = stat;

endmodule

// File: rtl/la_capture_checker.sv
module la_capture_checker #(
    parameter int PROBE_W = 32,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_wr_i,
    input logic [1:0]         cfg_sel_i,
    input logic               cfg_arm_bit_i,
    input logic [PROBE_W-1:0] rd_data_o,
    input logic [2:0]         status_o,
    input logic [CNT_W-1:0]   trig_delay_o
);

    logic arm_req;
    assign arm_req = cfg_wr_i && (cfg_sel_i == 2'd2) && cfg_arm_bit_i;

    p_legal_status_r6: assert property (@(posedge clk) disable iff (rst)
        (status_o == 3'b000) || (status_o == 3'b001) ||
        (status_o == 3'b010) || (status_o == 3'b110));

    p_idle_ignores_r4: assert property (@(posedge clk) disable iff (rst)
        (status_o == 3'b000 && !arm_req) |=> (status_o == 3'b000));

    p_done_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (status_o[2] && !arm_req) |=> (status_o == 3'b110 && $stable(trig_delay_o)));

    p_capture_stays_r5: assert property (@(posedge clk) disable iff (rst)
        (status_o == 3'b010 && !arm_req) |=> status_o[1]);

    p_arm_restarts_r9: assert property (@(posedge clk) disable iff (rst)
        arm_req |=> (status_o == 3'b001 && trig_delay_o == '0));

    p_read_gated_r7: assert property (@(posedge clk) disable iff (rst)
        !status_o[2] |=> (rd_data_o == '0));

endmodule

bind la_capture_top la_capture_checker #(
    .PROBE_W (PROBE_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr_i      (cfg_wr_i),
    .cfg_sel_i     (cfg_sel_i),
    .cfg_arm_bit_i (cfg_data_i[0]),
    .rd_data_o     (rd_data_o),
    .status_o      (status_o),
    .trig_delay_o  (trig_delay_o)
);

// File: tb/la_capture_top_test.sv
`timescale 1ns/1ps
module la_capture_top_test;

    localparam int PW = 8;
    localparam int TW = 4;
    localparam int DP = 16;
    localparam int CW = 6;
    localparam int AW = $clog2(DP);
    localparam logic [TW-1:0] MATCH = 4'b1010;

    logic          clk = 1'b0;
    logic          rst;
    logic [PW-1:0] probe_i;
    logic [TW-1:0] trig_i;
    logic          ext_trig_i;
    logic          cfg_wr_i;
    logic [1:0]    cfg_sel_i;
    logic [TW-1:0] cfg_data_i;
    logic [AW-1:0] rd_idx_i;
    logic [PW-1:0] rd_data_o;
    logic [2:0]    status_o;
    logic [CW-1:0] trig_delay_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pat_mul = 37;
    int pat_add = 11;
    int c0;

    always #4 clk = ~clk;

    la_capture_top #(.PROBE_W(PW), .TRIG_W(TW), .DEPTH(DP), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .probe_i(probe_i), .trig_i(trig_i),
        .ext_trig_i(ext_trig_i), .cfg_wr_i(cfg_wr_i), .cfg_sel_i(cfg_sel_i),
        .cfg_data_i(cfg_data_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
        .status_o(status_o), .trig_delay_o(trig_delay_o)
    );

    function automatic logic [PW-1:0] pat(int c);
        return PW'(c * pat_mul + pat_add);
    endfunction

    task automatic tick();
        @(negedge clk);
        cyc++;
        probe_i = pat(cyc);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg(logic [1:0] sel, logic [TW-1:0] data);
        cfg_wr_i = 1'b1; cfg_sel_i = sel; cfg_data_i = data;
        tick();
        cfg_wr_i = 1'b0;
    endtask

    task automatic readout(string req);
        for (int i = 0; i < DP; i++) begin
            rd_idx_i = AW'(i);
            tick();
            chk(req, 32'(rd_data_o), 32'(pat(c0 + i)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; probe_i = '0; trig_i = '0; ext_trig_i = 1'b0;
        cfg_wr_i = 1'b0; cfg_sel_i = '0; cfg_data_i = '0; rd_idx_i = '0;
        repeat (3) tick();
        chk("R1 status in reset", 32'(status_o), 0);
        rst = 1'b0;
        tick();
        chk("R1 status", 32'(status_o), 0);
        chk("R1 rd_data", 32'(rd_data_o), 0);
        chk("R1 delay", 32'(trig_delay_o), 0);

        // R4: idle ignores a matching trigger (reset mask all ones, match zero)
        trig_i = 4'b0000; ext_trig_i = 1'b1;
        repeat (5) tick();
        chk("R4 idle internal", 32'(status_o), 0);
        cfg(2'd2, 4'b0010);
        repeat (3) tick();
        chk("R4 idle external", 32'(status_o), 0);
        cfg(2'd2, 4'b0000);
        ext_trig_i = 1'b0;

        // R2 / R10: exhaustive mask x input sweep
        cfg(2'd0, MATCH);
        for (int m = 0; m < 16; m++) begin
            cfg(2'd1, TW'(m));
            for (int t = 0; t < 16; t++) begin
                logic hit_exp;
                hit_exp = ((TW'(t) & TW'(m)) == (MATCH & TW'(m)));
                trig_i = TW'(t);
                cfg(2'd2, 4'b0001);
                tick();
                chk("R2 sweep", 32'(status_o), hit_exp ? 32'h2 : 32'h1);
            end
        end

        // R5 / R7 / R8: capture after delay 3
        cfg(2'd1, 4'b1111);
        trig_i = 4'b0000;
        cfg(2'd2, 4'b0001);
        chk("R6 armed", 32'(status_o), 1);
        repeat (3) tick();
        trig_i = MATCH; c0 = cyc;
        tick();
        trig_i = 4'b0000;
        chk("R6 capturing", 32'(status_o), 2);
        rd_idx_i = '0;
        repeat (DP - 2) tick();
        chk("R5 not yet done", 32'(status_o), 2);
        chk("R7 read blocked", 32'(rd_data_o), 0);
        tick();
        chk("R5 done", 32'(status_o), 6);
        chk("R8 delay", 32'(trig_delay_o), 3);
        // R4: done ignores triggers
        trig_i = MATCH;
        repeat (4) tick();
        trig_i = 4'b0000;
        chk("R4 done status", 32'(status_o), 6);
        chk("R4 done delay", 32'(trig_delay_o), 3);
        readout("R5 R7 readout 1");

        // R9: re-arm from done
        cfg(2'd2, 4'b0001);
        chk("R9 rearm status", 32'(status_o), 1);
        chk("R9 rearm delay", 32'(trig_delay_o), 0);
        rd_idx_i = AW'(2);
        tick();
        chk("R9 read blocked", 32'(rd_data_o), 0);

        // second pattern, trigger on first armed cycle
        pat_mul = 53; pat_add = 200;
        cfg(2'd2, 4'b0001);
        trig_i = MATCH; c0 = cyc;
        tick();
        trig_i = 4'b0000;
        repeat (DP - 1) tick();
        chk("R5 done 2", 32'(status_o), 6);
        chk("R8 zero delay", 32'(trig_delay_o), 0);
        readout("R5 R7 readout 2");

        // R9: arm in the middle of capture
        cfg(2'd2, 4'b0001);
        trig_i = MATCH;
        tick();
        trig_i = 4'b0000;
        repeat (2) tick();
        chk("R9 mid capture", 32'(status_o), 2);
        cfg(2'd2, 4'b0001);
        chk("R9 restart", 32'(status_o), 1);

        // R3: external trigger
        cfg(2'd2, 4'b0011);
        ext_trig_i = 1'b1;
        tick();
        ext_trig_i = 1'b0;
        chk("R3 ext enabled", 32'(status_o), 2);
        cfg(2'd2, 4'b0001);
        ext_trig_i = 1'b1;
        repeat (2) tick();
        ext_trig_i = 1'b0;
        chk("R3 ext disabled", 32'(status_o), 1);

        // R8: saturation
        cfg(2'd2, 4'b0001);
        repeat (70) tick();
        chk("R8 saturated armed", 32'(trig_delay_o), 63);
        trig_i = MATCH;
        tick();
        trig_i = 4'b0000;
        chk("R8 saturated hold", 32'(trig_delay_o), 63);
        chk("R6 saturated trigger", 32'(status_o), 2);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule